// File: doc/BRIEF.md
# Banked 64x8 Memory

This block is a 64-word, 8-bit memory. Its storage is eight identical 16-word by 4-bit banks, arranged as four rows of two. The low four address bits pick a word inside every bank at once. The two high address bits pass through a 2-to-4 decoder, which pulls exactly one row's active-low chip enable low. Within a row, one bank holds the low nibble of each byte and the other holds the high nibble.

The controls are active low, as they are on the banks:
- select (`csN`)
- write (`weN`)
- output (`oeN`)

A write is captured on the rising clock edge while select and write are both low. A read is requested when select is low, write is high and output is low. Its data appears one cycle later together with `rdValid`. There is no bidirectional bus. A row multiplexer, steered by the row registered with the read, returns the byte. The output is forced to zero whenever the valid flag is low.

Top module: `memBankArray`

## Requirements
- R1: Every one of the 64 byte addresses stores its own value, and that value reads back unchanged until the address is written again.
- R2: `addr[5:4]` selects the row and `addr[3:0]` the word inside it, so adjacent addresses across a row boundary (15/16, 31/32, 47/48) hold independent values.
- R3: `wrData[3:0]` and `wrData[7:4]` are kept in separate banks of the same row and return at the same bit positions of `rdData`.
- R4: The per-row chip enables are active low: exactly one is low (the row numbered by `addr[5:4]`) while `csN` is low, and all are high while `csN` is high.
- R5: A rising clock edge with `csN`=0 and `weN`=0 stores `wrData` at `addr`.
- R6: A rising clock edge with `csN`=0, `weN`=1 and `oeN`=0 makes `rdValid` 1 in the following cycle, with `rdData` equal to the byte stored at `addr`.
- R7: After any edge not meeting the R6 condition, `rdValid` is 0 and `rdData` is 0 in the following cycle.
- R8: With `csN`=1 the memory is not changed, whatever `weN`, `oeN` and `wrData` are.
- R9: While and after reset (`rstN`=0), `rdValid` is 0 and `rdData` is 0 until the first read is accepted. Memory contents are not cleared.
- R10: When `weN` and `oeN` are both low with `csN` low, the write is performed and no read is reported: `rdValid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the read-side registers |
| csN | input | 1 | Active-low chip select |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addr | input | 6 | Byte address: [5:4] row, [3:0] word |
| wrData | input | 8 | Byte to store |
| rdData | output | 8 | Byte read, zero when not valid |
| rdValid | output | 1 | High in the cycle after an accepted read |

## Verification
On every cycle, the assertions check four things:
- The row decoder (one-low or all-high enables).
- The one-cycle relation between a legal read request and `rdValid`.
- Write priority over output enable.
- The zero output when not valid.

Whether the right byte comes back needs more than one cycle to show, and only the bench's scenarios can do it. They cover:
- Whether neighbouring rows across the 15/16, 31/32 and 47/48 boundaries stay apart.
- Whether each nibble lands in its own bank.
- Whether a deselected write leaves memory untouched.

The bench checks these against a 64-entry reference model.

// File: rtl/memPkg.sv
package memPkg;
  localparam int ADDR_W      = 6;
  localparam int DATA_W      = 8;
  localparam int BANK_ADDR_W = 4;
  localparam int BANK_DATA_W = 4;
  localparam int ROW_IDX_W   = ADDR_W - BANK_ADDR_W;
  localparam int ROWS        = 1 << ROW_IDX_W;
  localparam int COLS        = DATA_W / BANK_DATA_W;

  // strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;      // write accepted this edge
    logic                 rdEn;      // read accepted this edge
    logic [ROW_IDX_W-1:0] rdRowQ;    // row of the last accepted read
    logic                 rdValidQ;  // read data valid this cycle
  } strobes_t;
endpackage

// File: rtl/memBank.sv
module memBank #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          ceN,
  input  logic          weN,
  input  logic          oeN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] storage [DEPTH];
  logic [DW-1:0] rdQ;

  // write wins over output enable; read only with write inactive
  always_ff @(posedge clk) begin
    if (!ceN && !weN) storage[addr] <= wrData;
    if (!ceN && weN && !oeN) rdQ <= storage[addr];
  end

  assign rdData = rdQ;
endmodule

// File: rtl/memCtrl.sv
module memCtrl
  import memPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 weN,
  input  logic                 oeN,
  input  logic [ROW_IDX_W-1:0] addrHi,
  output logic [ROWS-1:0]      rowCeN,
  output strobes_t             strobes
);
  logic                 wrEn;
  logic                 rdEn;
  logic                 rdValidQ;
  logic [ROW_IDX_W-1:0] rdRowQ;

  // active-low row decoder, all rows off while deselected
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      rowCeN[r] = csN | (addrHi != ROW_IDX_W'(r));
    end
  end

  assign wrEn = !csN && !weN;
  assign rdEn = !csN && weN && !oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      rdRowQ   <= '0;
    end else begin
      rdValidQ <= rdEn;
      if (rdEn) rdRowQ <= addrHi;
    end
  end

  always_comb begin
    strobes.wrEn     = wrEn;
    strobes.rdEn     = rdEn;
    strobes.rdRowQ   = rdRowQ;
    strobes.rdValidQ = rdValidQ;
  end
endmodule

// File: rtl/memDatapath.sv
module memDatapath
  import memPkg::*;
(
  input  logic                   clk,
  input  logic [ROWS-1:0]        rowCeN,
  input  strobes_t               strobes,
  input  logic [BANK_ADDR_W-1:0] addrLo,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData
);
  logic [BANK_DATA_W-1:0] bankRd [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      memBank #(
        .AW(BANK_ADDR_W),
        .DW(BANK_DATA_W)
      ) u_bank (
        .clk   (clk),
        .ceN   (rowCeN[r]),
        .weN   (!strobes.wrEn),
        .oeN   (!strobes.rdEn),
        .addr  (addrLo),
        .wrData(wrData[c*BANK_DATA_W +: BANK_DATA_W]),
        .rdData(bankRd[r][c])
      );
    end
  end

  // row mux replaces the shared tristate bus
  always_comb begin
    rdData = '0;
    if (strobes.rdValidQ) begin
      for (int c = 0; c < COLS; c++) begin
        rdData[c*BANK_DATA_W +: BANK_DATA_W] = bankRd[strobes.rdRowQ][c];
      end
    end
  end
endmodule

// File: rtl/memBankArray.sv
module memBankArray
  import memPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [ROWS-1:0] rowCeN;
  strobes_t        strobes;

  memCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .weN    (weN),
    .oeN    (oeN),
    .addrHi (addr[ADDR_W-1:BANK_ADDR_W]),
    .rowCeN (rowCeN),
    .strobes(strobes)
  );

  memDatapath u_dp (
    .clk    (clk),
    .rowCeN (rowCeN),
    .strobes(strobes),
    .addrLo (addr[BANK_ADDR_W-1:0]),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign rdValid = strobes.rdValidQ;
endmodule

// File: rtl/memBankArrayChk.sv
module memBankArrayChk
  import memPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 weN,
  input logic                 oeN,
  input logic [ROW_IDX_W-1:0] addrHi,
  input logic [ROWS-1:0]      rowCeN,
  input logic [DATA_W-1:0]    rdData,
  input logic                 rdValid
);
  // R4
  row_onehot_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> ($countones(~rowCeN) == 1 && !rowCeN[addrHi]));

  // R4
  row_all_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (&rowCeN));

  // R6
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && weN && !oeN) |=> rdValid);

  // R7
  no_read_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!csN && weN && !oeN) |=> !rdValid);

  // R10
  write_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !weN && !oeN) |=> !rdValid);

  // R7
  zero_when_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));
endmodule

bind memBankArray memBankArrayChk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .csN    (csN),
  .weN    (weN),
  .oeN    (oeN),
  .addrHi (addr[5:4]),
  .rowCeN (rowCeN),
  .rdData (rdData),
  .rdValid(rdValid)
);

// File: tb/test_memBankArray.sv
module test_memBankArray;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       weN = 1'b1;
  logic       oeN = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rdValid;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] model [64];

  always #4 clk = ~clk;  // 125 MHz

  memBankArray i_memBankArray (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected read result for a control combination
  function automatic logic [8:0] expectOut(input logic c, input logic w,
                                           input logic o, input logic [5:0] a);
    logic rd;
    rd = !c && w && !o;
    return rd ? {1'b1, model[a]} : 9'h000;
  endfunction

  task automatic doOp(input string req, input logic c, input logic w,
                      input logic o, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    csN = c; weN = w; oeN = o; addr = a; wrData = d;
    @(posedge clk);
    if (!c && !w) model[a] = d;
    #1;
    check(req, {rdValid, rdData}, expectOut(c, w, o, a));
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", {rdValid, rdData}, 9'h000);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R9 after reset", {rdValid, rdData}, 9'h000);

    // fill every address, then read each back
    for (int a = 0; a < 64; a++) doOp("R5 fill", 1'b0, 1'b0, 1'b1, 6'(a), 8'($urandom));
    for (int a = 0; a < 64; a++) doOp("R1 readback", 1'b0, 1'b1, 1'b0, 6'(a), 8'h00);

    // row boundaries: R2 and R4 (no row clobbers another)
    for (int k = 1; k < 4; k++) begin
      doOp("R2 below boundary", 1'b0, 1'b0, 1'b1, 6'(k*16-1), 8'(8'hC0 + k));
      doOp("R2 above boundary", 1'b0, 1'b0, 1'b1, 6'(k*16), 8'(8'h30 + k));
    end
    for (int k = 1; k < 4; k++) begin
      doOp("R2 R4 read below", 1'b0, 1'b1, 1'b0, 6'(k*16-1), 8'h00);
      doOp("R2 R4 read above", 1'b0, 1'b1, 1'b0, 6'(k*16), 8'h00);
    end

    // nibble placement
    doOp("R3 write", 1'b0, 1'b0, 1'b1, 6'd37, 8'hA5);
    doOp("R3 read", 1'b0, 1'b1, 1'b0, 6'd37, 8'h00);
    doOp("R3 write", 1'b0, 1'b0, 1'b1, 6'd37, 8'h5A);
    doOp("R3 read", 1'b0, 1'b1, 1'b0, 6'd37, 8'h00);
    doOp("R3 write", 1'b0, 1'b0, 1'b1, 6'd38, 8'hF0);
    doOp("R3 read", 1'b0, 1'b1, 1'b0, 6'd38, 8'h00);

    // deselected write leaves memory alone
    doOp("R8 deselected write", 1'b1, 1'b0, 1'b1, 6'd37, 8'h11);
    doOp("R8 deselected both low", 1'b1, 1'b0, 1'b0, 6'd37, 8'h22);
    doOp("R8 readback", 1'b0, 1'b1, 1'b0, 6'd37, 8'h00);

    // write enable and output enable both low
    doOp("R10 both low", 1'b0, 1'b0, 1'b0, 6'd63, 8'h7E);
    doOp("R10 R5 readback", 1'b0, 1'b1, 1'b0, 6'd63, 8'h00);

    // output enable high gives no read
    doOp("R7 oe high", 1'b0, 1'b1, 1'b1, 6'd0, 8'h00);
    doOp("R6 read", 1'b0, 1'b1, 1'b0, 6'd0, 8'h00);
    doOp("R7 idle", 1'b1, 1'b1, 1'b1, 6'd0, 8'h00);

    // constrained random mix, mostly legal reads and writes
    for (int i = 0; i < 1500; i++) begin
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 9));
      case (pick)
        4'd0, 4'd1, 4'd2: doOp("R5 random write", 1'b0, 1'b0, 1'b1, 6'($urandom), 8'($urandom));
        4'd3, 4'd4, 4'd5: doOp("R6 random read", 1'b0, 1'b1, 1'b0, 6'($urandom), 8'($urandom));
        4'd6:             doOp("R8 random deselect", 1'b1, 1'($urandom), 1'($urandom), 6'($urandom), 8'($urandom));
        4'd7:             doOp("R10 random both low", 1'b0, 1'b0, 1'b0, 6'($urandom), 8'($urandom));
        default:          doOp("R7 random no read", 1'b0, 1'b1, 1'b1, 6'($urandom), 8'($urandom));
      endcase
    end

    // final sweep of all addresses
    for (int a = 0; a < 64; a++) doOp("R1 final sweep", 1'b0, 1'b1, 1'b0, 6'(a), 8'h00);
    summary();
  end
endmodule